// File: doc/BRIEF.md
# CRC-32 / CRC-32C Instruction Unit

This execution unit produces the result of a CRC instruction. It receives a 32-bit running CRC value, a 64-bit message operand, a two-bit size code and a variant select. It trims the message to the requested number of bytes. It then folds those bytes into the running value with a reflected, shift-right CRC update, starting from the lowest byte.

One datapath serves two polynomials. The CRC-32 variant returns the final state as it is. The CRC-32C variant returns the final state with every bit inverted. The 32-bit outcome is delivered sign-extended to 64 bits, so that it can be written straight into a 64-bit destination register.

Work is issued with a single-cycle `start` strobe, which captures all operands. The unit then consumes one message byte per clock. It raises `done` for one cycle when `result` holds the new value. Decode and register-file access sit outside this block.

Top module: `crcu_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `done` is cleared to 0 and `result` is cleared to all zeros.
- R2: The size code selects the byte count: 0 → 1 byte, 1 → 2 bytes, 2 → 4 bytes, 3 → 8 bytes. Message bytes at or above that count are treated as zero and do not change the result.
- R3: Message bytes are consumed from bits 7:0 upward (byte k is `msg[8k+7:8k]`), so swapping two bytes of the operand changes the result.
- R4: With `variant` = 0 (CRC-32), the state starts as `crc_in`. Each bit step uses the reflected polynomial 0xEDB88320 (if bit 0 is set, shift right and XOR the polynomial; otherwise shift right). The final state is returned unchanged.
- R5: With `variant` = 1 (CRC-32C), the state starts as `crc_in`, the polynomial is 0x82F63B78, and all 32 bits of the final state are inverted before output.
- R6: `result[63:32]` equals 32 copies of `result[31]`.
- R7: `done` is high for exactly one cycle. It rises N clock edges after the edge that captured `start`, where N is the byte count from R2.
- R8: A `start` that arrives while an operation is in progress is ignored. The running operation finishes with its own result and latency, and no extra `done` follows.
- R9: Operands are taken only at the capturing edge. Changing `crc_in`, `msg`, `size` or `variant` afterwards has no effect on the pending result.
- R10: `result` keeps its value in every cycle in which `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Issue strobe; operands are captured when the unit is idle |
| size | input | 2 | Byte count code: 0=1, 1=2, 2=4, 3=8 bytes |
| variant | input | 1 | 0 = CRC-32, 1 = CRC-32C |
| crc_in | input | 32 | Running CRC value used as the starting state |
| msg | input | 64 | Message operand, least significant byte consumed first |
| done | output | 1 | One-cycle pulse marking a new valid result |
| result | output | 64 | Sign-extended 32-bit CRC result |

## Verification
A corrupted CRC state, shifted message register or latched variant never shows up until the `done` pulse. It then appears as a wrong `result`, N+1 cycles after `start` at the latest, so every operation is compared in full against a bit-serial model. A miscounted byte counter shows up in the same window, either as `done` arriving on the wrong cycle or as a result built from too many or too few bytes. For that reason the bench measures the latency of each operation as well as its value. A busy flag that drops too early, or an input latched too late, becomes visible only when operands change or `start` repeats during an operation, and dedicated scenarios create exactly those conditions.

// File: rtl/crcu_pkg.sv
// crcu_pkg: shared constants and types for the CRC instruction unit.
// Assumes a 32-bit CRC register and byte-wide message feed.
package crcu_pkg;
    localparam int CRC_W  = 32;
    localparam int BYTE_W = 8;

    localparam logic [CRC_W-1:0] POLY_IEEE = 32'hEDB88320;
    localparam logic [CRC_W-1:0] POLY_CAST = 32'h82F63B78;

    typedef enum logic {
        VAR_IEEE = 1'b0,
        VAR_CAST = 1'b1
    } crc_variant_e;
endpackage

// File: rtl/crcu_byte_step.sv
// crcu_byte_step: combinational update of a reflected CRC state by one byte.
// Eight shift-right bit steps are unrolled; the polynomial is an input so one
// instance serves both variants. Assumes DATA_W <= CRC_W.
module crcu_byte_step #(
    parameter int CRC_W  = 32,
    parameter int DATA_W = 8
) (
    input  logic [CRC_W-1:0]  state_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CRC_W-1:0]  poly_i,
    output logic [CRC_W-1:0]  state_o
);
    logic [CRC_W-1:0] chain [0:DATA_W];

    // Fold the incoming byte into the low bits of the state.
    assign chain[0] = state_i ^ {{(CRC_W-DATA_W){1'b0}}, data_i};

    for (genvar k = 0; k < DATA_W; k++) begin : g_bit
        // One reflected bit step: shift right, XOR polynomial on a set LSB.
        assign chain[k+1] = chain[k][0] ? ((chain[k] >> 1) ^ poly_i)
                                        : (chain[k] >> 1);
    end

    assign state_o = chain[DATA_W];
endmodule

// File: rtl/crcu_seq.sv
// crcu_seq: sequencing for the byte-serial CRC unit. Accepts start only when
// idle, counts the bytes still to be consumed, and pulses done on the edge
// that consumes the last byte. Assumes MAX_BYTES is a power of two.
module crcu_seq #(
    parameter int MAX_BYTES = 8,
    parameter int SIZE_W    = 2,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SIZE_W-1:0] size,
    output logic              accept_o,
    output logic              busy_o,
    output logic              last_o,
    output logic [CNT_W-1:0]  remain_o,
    output logic              done_o
);
    logic [CNT_W-1:0] nbytes;

    // Decode the size code into a byte count (1 << code).
    assign nbytes   = CNT_W'(1) << size;
    assign accept_o = start && !busy_o;
    assign last_o   = busy_o && (remain_o == CNT_W'(1));

    // Busy flag, byte countdown and single-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o   <= 1'b0;
            remain_o <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (accept_o) begin
                busy_o   <= 1'b1;
                remain_o <= nbytes;
            end else if (busy_o) begin
                remain_o <= remain_o - CNT_W'(1);
                if (last_o) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/crcu_top.sv
// crcu_top: CRC-32 / CRC-32C instruction unit. Captures operands on an
// accepted start, masks the message to 1/2/4/8 bytes, consumes one byte per
// cycle lowest first, and registers the sign-extended result with done.
// Assumes RES_W >= 32 and MSG_W a multiple of 8.
module crcu_top #(
    parameter int MSG_W = 64,
    parameter int RES_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       size,
    input  logic             variant,
    input  logic [31:0]      crc_in,
    input  logic [MSG_W-1:0] msg,
    output logic             done,
    output logic [RES_W-1:0] result
);
    import crcu_pkg::*;

    localparam int MAX_BYTES = MSG_W / BYTE_W;
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);

    logic                 accept, busy, last;
    logic [CNT_W-1:0]     remain;
    logic [CRC_W-1:0]     state_q, state_nx, poly, final_crc;
    logic [MSG_W-1:0]     msg_q, msg_masked;
    crc_variant_e         var_q;
    logic [CNT_W-1:0]     req_bytes;

    crcu_seq #(
        .MAX_BYTES(MAX_BYTES),
        .SIZE_W   (2),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .size    (size),
        .accept_o(accept),
        .busy_o  (busy),
        .last_o  (last),
        .remain_o(remain),
        .done_o  (done)
    );

    // Zero every message byte at or above the requested byte count.
    assign req_bytes = CNT_W'(1) << size;
    always_comb begin
        for (int i = 0; i < MAX_BYTES; i++) begin
            msg_masked[i*BYTE_W +: BYTE_W] =
                (CNT_W'(i) < req_bytes) ? msg[i*BYTE_W +: BYTE_W] : '0;
        end
    end

    // Pick the polynomial of the latched variant.
    assign poly = (var_q == VAR_CAST) ? POLY_CAST : POLY_IEEE;

    crcu_byte_step #(
        .CRC_W (CRC_W),
        .DATA_W(BYTE_W)
    ) u_step (
        .state_i(state_q),
        .data_i (msg_q[BYTE_W-1:0]),
        .poly_i (poly),
        .state_o(state_nx)
    );

    // Output convention: CRC-32C inverts the final state, CRC-32 does not.
    assign final_crc = (var_q == VAR_CAST) ? ~state_nx : state_nx;

    // Operand capture and per-byte advance of state and message.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            msg_q   <= '0;
            var_q   <= VAR_IEEE;
        end else if (accept) begin
            state_q <= crc_in;
            msg_q   <= msg_masked;
            var_q   <= crc_variant_e'(variant);
        end else if (busy) begin
            state_q <= state_nx;
            msg_q   <= msg_q >> BYTE_W;
        end
    end

    // Result register: loaded with the sign-extended CRC on the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (last) begin
            result <= {{(RES_W-CRC_W){final_crc[CRC_W-1]}}, final_crc};
        end
    end
endmodule

// File: rtl/crcu_checker.sv
// crcu_checker: protocol properties of crcu_top, attached by bind.
// Observes the top-level ports plus the sequencer's busy flag and countdown.
module crcu_checker #(
    parameter int CNT_W = 4,
    parameter int RES_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [1:0]       size,
    input logic             done,
    input logic [RES_W-1:0] result,
    input logic             busy,
    input logic [CNT_W-1:0] remain
);
    // R7: completion is a single-cycle pulse.
    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: consuming the final byte raises done on the next cycle.
    a_r7_last_byte_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && remain == CNT_W'(1)) |=> done);

    // R2: an accepted start loads the byte count decoded from size.
    a_r2_capture_count: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && remain == (CNT_W'(1) << $past(size))));

    // R8: a start seen while busy does not reload the countdown.
    a_r8_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && remain > CNT_W'(1)) |=>
            (busy && remain == CNT_W'($past(remain) - CNT_W'(1))));

    // R10: result changes only together with done.
    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
endmodule

bind crcu_top crcu_checker #(.CNT_W(CNT_W), .RES_W(RES_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .size  (size),
    .done  (done),
    .result(result),
    .busy  (busy),
    .remain(remain)
);

// File: tb/crcu_top_test.sv
// crcu_top_test: directed bench for crcu_top; a bit-serial model gives the
// expected values, and each scenario task checks its own outcome.
module crcu_top_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [1:0]  size;
    logic        variant;
    logic [31:0] crc_in;
    logic [63:0] msg;
    logic        done;
    logic [63:0] result;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    crcu_top uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .size   (size),
        .variant(variant),
        .crc_in (crc_in),
        .msg    (msg),
        .done   (done),
        .result (result)
    );

    // Reference model written directly from the requirements (R2-R6).
    function automatic logic [63:0] model(logic v, logic [1:0] sz,
                                          logic [31:0] c, logic [63:0] m);
        logic [31:0] p = v ? 32'h82F63B78 : 32'hEDB88320;
        int n = 1 << sz;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'd0, m[i*8 +: 8]};
            for (int b = 0; b < 8; b++)
                c = c[0] ? ((c >> 1) ^ p) : (c >> 1);
        end
        if (v) c = ~c;
        return {{32{c[31]}}, c};
    endfunction

    task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // Drive one start strobe; returns at the negedge after the capture edge.
    task automatic launch(logic v, logic [1:0] sz, logic [31:0] c, logic [63:0] m);
        @(negedge clk);
        start = 1'b1; variant = v; size = sz; crc_in = c; msg = m;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Wait for done, counting cycles since the capture edge.
    task automatic wait_done(inout int lat, output logic [63:0] res);
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        res = result;
    endtask

    // Full operation with value, latency and pulse-width checks.
    task automatic run_check(string req, logic v, logic [1:0] sz,
                             logic [31:0] c, logic [63:0] m);
        int lat = 0;
        logic [63:0] res;
        launch(v, sz, c, m);
        wait_done(lat, res);
        chk(req, "result", res, model(v, sz, c, m));
        chk("R7", "latency", 64'(lat), 64'(1 << sz));
        @(negedge clk);
        chk("R7", "done width", 64'(done), 64'd0);
    endtask

    task automatic t_reset();
        chk("R1", "done after reset", 64'(done), 64'd0);
        chk("R1", "result after reset", result, 64'd0);
    endtask

    task automatic t_sweep();
        logic [63:0] pats [3] = '{64'h0123_4567_89AB_CDEF,
                                  64'hFFFF_0000_A5A5_5A5A,
                                  64'h8000_0000_0000_0001};
        for (int v = 0; v < 2; v++)
            for (int s = 0; s < 4; s++)
                for (int p = 0; p < 3; p++)
                    run_check(v ? "R5" : "R4", v[0], s[1:0],
                              32'hFFFF_FFFF ^ (32'(p) * 32'h1357_9BDF), pats[p]);
    endtask

    task automatic t_zero();
        run_check("R4", 1'b0, 2'd3, 32'd0, 64'd0);
        chk("R4", "zero in CRC-32", result, 64'd0);
        run_check("R5", 1'b1, 2'd3, 32'd0, 64'd0);
        chk("R6", "inverted zero sign-extended", result, 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_mask();
        for (int s = 0; s < 3; s++) begin
            int lat = 0;
            logic [63:0] res, full, trimmed;
            full    = 64'hDEAD_BEEF_CAFE_BA12;
            trimmed = full & ((64'd1 << (8 << s)) - 64'd1);
            launch(1'b0, s[1:0], 32'h1234_5678, full);
            wait_done(lat, res);
            chk("R2", "upper bytes ignored", res, model(1'b0, s[1:0], 32'h1234_5678, trimmed));
            chk("R6", "sign extension", {32'd0, res[63:32]}, {32'd0, {32{res[31]}}});
        end
    endtask

    task automatic t_order();
        int lat = 0;
        logic [63:0] a, b;
        launch(1'b1, 2'd1, 32'hFFFF_FFFF, 64'h0102);
        wait_done(lat, a);
        lat = 0;
        launch(1'b1, 2'd1, 32'hFFFF_FFFF, 64'h0201);
        wait_done(lat, b);
        chk("R3", "low byte first", a, model(1'b1, 2'd1, 32'hFFFF_FFFF, 64'h0102));
        n_chk++;
        if (a === b) begin
            n_fail++;
            $display("FAIL R3 byte swap: actual %h expected a value other than %h", b, a);
        end
    endtask

    task automatic t_busy();
        int lat = 0, extra = 0;
        logic [63:0] res;
        launch(1'b0, 2'd3, 32'hA5A5_A5A5, 64'h1122_3344_5566_7788);
        @(negedge clk);
        start = 1'b1; variant = 1'b1; size = 2'd0; crc_in = 32'h0; msg = 64'hFF;
        @(negedge clk);
        start = 1'b0;
        lat = 2;
        wait_done(lat, res);
        chk("R8", "first result kept", res, model(1'b0, 2'd3, 32'hA5A5_A5A5, 64'h1122_3344_5566_7788));
        chk("R8", "latency unchanged", 64'(lat), 64'd8);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (i > 0 && done) extra++;
        end
        chk("R8", "no second done", 64'(extra), 64'd0);
        chk("R10", "result held", result, res);
    endtask

    task automatic t_change();
        int lat = 0;
        logic [63:0] res;
        launch(1'b1, 2'd2, 32'h0BAD_F00D, 64'h0000_0000_8765_4321);
        variant = 1'b0; size = 2'd3; crc_in = 32'h0; msg = '1;
        wait_done(lat, res);
        chk("R9", "late operand change ignored", res,
            model(1'b1, 2'd2, 32'h0BAD_F00D, 64'h0000_0000_8765_4321));
        chk("R9", "latency from captured size", 64'(lat), 64'd4);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R7 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; size = '0; variant = 1'b0; crc_in = '0; msg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sweep();
        t_zero();
        t_mask();
        t_order();
        t_busy();
        t_change();
        finish_run();
    end
endmodule